// File: doc/BRIEF.md
# Transparent Cyclic Byte Transmitter

This block turns bytes held in a small transmit queue into a raw serial stream. It adds no framing of any kind: no opening or closing flags, no checksum, no zero-bit insertion. A host pushes bytes in through a write strobe and controls the block through an 8-bit command write. One bit leaves the block per pulse of a line-rate enable. Every transmission starts with one all-ones synchronization byte, followed by the queued bytes, least significant bit first. When nothing is being sent, the line rests at logic 1.

A command selects one of two ways to send. In one-shot mode the queue is sent once and drained. In cyclic mode the stored bytes form a pattern that repeats without being consumed. The pattern continues until a reset command arrives, or until a command write comes in with the repeat bit clear.

The controller is a three-state machine. `ST_IDLE` drives ones. `ST_SYNC` sends the synchronization byte. `ST_DATA` sends queued bytes. The transitions are named as follows:
- **start** goes from `ST_IDLE` to `ST_SYNC`.
- **sync-end** goes from `ST_SYNC` to `ST_DATA`, or back to `ST_IDLE` when the queue is empty.
- **wrap-step** stays in `ST_DATA` and moves to the next pattern byte.
- **pop-step** consumes a byte and returns to `ST_IDLE` after the last one.
- **stop** and **reset** go from any state to `ST_IDLE`.

Top module: `xpt_cyclic_tx`

## Requirements
- R1: After reset, and whenever no transmission is active, `tx_bit` is 1, and `fifo_ovf` is 0 after reset.
- R2: A command write with bit 2 (start) set while idle sends eight 1 bits, then each queued byte unchanged, least significant bit first, one bit per `tx_clk_en` pulse. In one-shot mode (bit 5 clear) each byte is consumed, and the line returns to 1 after the last byte.
- R3: A start with an empty queue sends only the synchronization byte and then returns to idle. A byte written after that waits for the next start.
- R4: A start with bit 5 (repeat) also set, for example command 0x24, sends the 1 to 32 stored bytes repeatedly. After the last byte it wraps to the first byte, and no entry is consumed.
- R5: During cyclic sending, a command write with bit 5 set lets the pattern continue. This holds even when the write lands on the last bit of a byte. A command write with bit 5 clear stops at once: the line goes to 1, and the stored bytes are kept.
- R6: A command write with bit 0 (reset) set has priority over the other bits. Within one clock it empties the queue, clears the repeat state and the overflow flag, and returns to idle.
- R7: A byte write to a queue that already holds 32 bytes is ignored and sets `fifo_ovf`. The flag stays set until a reset command.
- R8: `tx_bit` changes only on clock edges where `tx_clk_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_wr | input | 1 | Byte write strobe into the transmit queue |
| fifo_wdata | input | 8 | Byte to queue |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command: bit 0 reset, bit 2 start, bit 5 repeat |
| tx_clk_en | input | 1 | Line-rate enable, one bit out per pulse |
| tx_bit | output | 1 | Serial output, idles at 1 |
| fifo_ovf | output | 1 | Sticky overflow flag |

## Verification
Two events can fall in the same cycle: a keep-going command write (repeat bit set) and the final bit of a pattern byte, which advances the pattern offset. The bench provokes this by raising `cmd_wr` with value 0x24 together with the `tx_clk_en` pulse of bit 7. A correct design must not let the command swallow the byte step. The bench judges this by checking that the next two bytes on the line are the following pattern bytes, not a repeat of the current one.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_DATA = 2'd2
    } tx_state_e;

    typedef enum logic [2:0] {
        TR_NONE,
        TR_RESET,
        TR_STOP,
        TR_START,
        TR_SYNC_END,
        TR_WRAP_STEP,
        TR_POP_STEP
    } tx_trans_e;

    localparam int CMD_W          = 8;
    localparam int CMD_RESET_BIT  = 0;
    localparam int CMD_START_BIT  = 2;
    localparam int CMD_REPEAT_BIT = 5;

endpackage

// File: rtl/xpt_fifo.sv
module xpt_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          wr_en,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          pop,
    input  logic                          cyc_adv,
    input  logic                          cyc_rewind,
    output logic [DATA_W-1:0]             rd_data,
    output logic [$clog2(DEPTH):0]        count,
    output logic                          empty,
    output logic                          ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     head_q, tail_q, off_q;
    logic [CW-1:0]     count_q;
    logic              ovf_q;
    logic              full, wr_ok, pop_ok;
    logic [CW-1:0]     addr_sum;
    logic [AW-1:0]     rd_addr;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full   = (count_q == CW'(DEPTH));
    assign empty  = (count_q == '0);
    assign wr_ok  = wr_en && !full;
    assign pop_ok = pop && !empty;

    assign addr_sum = {1'b0, head_q} + {1'b0, off_q};
    assign rd_addr  = (addr_sum >= CW'(DEPTH)) ? AW'(addr_sum - CW'(DEPTH))
                                               : AW'(addr_sum);
    assign rd_data  = mem[rd_addr];
    assign count    = count_q;
    assign ovf      = ovf_q;

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[tail_q] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            off_q   <= '0;
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else if (clear) begin
            head_q  <= '0;
            tail_q  <= '0;
            off_q   <= '0;
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            if (wr_ok) begin
                tail_q <= step_ptr(tail_q);
            end
            if (pop_ok) begin
                head_q <= step_ptr(head_q);
            end
            count_q <= count_q + CW'(wr_ok) - CW'(pop_ok);
            if (wr_en && full) begin
                ovf_q <= 1'b1;
            end
            if (cyc_rewind) begin
                off_q <= '0;
            end else if (cyc_adv) begin
                off_q <= ((CW'(off_q) + 1'b1) >= count_q) ? '0 : off_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/xpt_shifter.sv
module xpt_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              sending,
    input  logic              restart,
    input  logic [DATA_W-1:0] byte_in,
    output logic              tx_bit,
    output logic              byte_done
);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BW-1:0] LAST_IDX = BW'(DATA_W - 1);

    logic [BW-1:0] bidx_q;
    logic          line_q;

    assign byte_done = shift_en && sending && (bidx_q == LAST_IDX);
    assign tx_bit    = line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bidx_q <= '0;
            line_q <= 1'b1;
        end else begin
            if (shift_en) begin
                line_q <= sending ? byte_in[bidx_q] : 1'b1;
            end
            if (restart) begin
                bidx_q <= '0;
            end else if (shift_en && sending) begin
                bidx_q <= (bidx_q == LAST_IDX) ? '0 : bidx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/xpt_ctrl.sv
module xpt_ctrl
    import xpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_data,
    input  logic             byte_done,
    input  logic             fifo_empty,
    input  logic             fifo_last,
    output tx_state_e        state_o,
    output logic             rep_o,
    output logic             pop,
    output logic             cyc_adv,
    output logic             cyc_rewind,
    output logic             fifo_clear,
    output logic             restart
);
    localparam logic [CMD_W-1:0] CMD_USED =
        (CMD_W'(1) << CMD_RESET_BIT) | (CMD_W'(1) << CMD_START_BIT) |
        (CMD_W'(1) << CMD_REPEAT_BIT);

    tx_state_e state_q, state_d;
    logic      rep_q, rep_d;
    tx_trans_e tr;
    logic      do_reset, do_start, want_rep;
    logic      unused_cmd_bits;

    assign do_reset        = cmd_data[CMD_RESET_BIT];
    assign do_start        = cmd_data[CMD_START_BIT];
    assign want_rep        = cmd_data[CMD_REPEAT_BIT];
    assign unused_cmd_bits = ^(cmd_data & ~CMD_USED);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rep_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rep_q   <= rep_d;
        end
    end

    // transition selection: commands first, then the byte step
    always_comb begin
        tr = TR_NONE;
        if (cmd_wr && do_reset) begin
            tr = TR_RESET;
        end else if (cmd_wr && rep_q && !want_rep) begin
            tr = TR_STOP;
        end else if (cmd_wr && (state_q == ST_IDLE) && do_start) begin
            tr = TR_START;
        end else if (byte_done) begin
            unique case (state_q)
                ST_SYNC: tr = TR_SYNC_END;
                ST_DATA: tr = rep_q ? TR_WRAP_STEP : TR_POP_STEP;
                default: tr = TR_NONE;
            endcase
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        rep_d   = rep_q;
        unique case (tr)
            TR_RESET, TR_STOP: begin
                state_d = ST_IDLE;
                rep_d   = 1'b0;
            end
            TR_START: begin
                state_d = ST_SYNC;
                rep_d   = want_rep;
            end
            TR_SYNC_END: begin
                if (fifo_empty) begin
                    state_d = ST_IDLE;
                    rep_d   = 1'b0;
                end else begin
                    state_d = ST_DATA;
                end
            end
            TR_POP_STEP: begin
                if (fifo_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = state_q;
            end
        endcase
    end

    // outputs
    always_comb begin
        fifo_clear = (tr == TR_RESET);
        restart    = (tr == TR_RESET) || (tr == TR_STOP) || (tr == TR_START);
        cyc_rewind = (tr == TR_START);
        cyc_adv    = (tr == TR_WRAP_STEP);
        pop        = (tr == TR_POP_STEP);
    end

    assign state_o = state_q;
    assign rep_o   = rep_q;

endmodule

// File: rtl/xpt_cyclic_tx.sv
module xpt_cyclic_tx
    import xpt_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_wr,
    input  logic [DATA_W-1:0] fifo_wdata,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_data,
    input  logic              tx_clk_en,
    output logic              tx_bit,
    output logic              fifo_ovf
);
    localparam int CW = $clog2(FIFO_DEPTH) + 1;
    localparam logic [DATA_W-1:0] SYNC_PATTERN = {DATA_W{1'b1}};

    tx_state_e         state_q;
    logic              rep_q;
    logic              pop, cyc_adv, cyc_rewind, fifo_clear, restart;
    logic              byte_done, fifo_empty, fifo_last, sending;
    logic [CW-1:0]     fifo_count;
    logic [DATA_W-1:0] fifo_rd, byte_in;

    assign fifo_last = (fifo_count == CW'(1));
    assign sending   = (state_q != ST_IDLE);
    assign byte_in   = (state_q == ST_SYNC) ? SYNC_PATTERN : fifo_rd;

    xpt_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (FIFO_DEPTH)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (fifo_clear),
        .wr_en      (fifo_wr),
        .wr_data    (fifo_wdata),
        .pop        (pop),
        .cyc_adv    (cyc_adv),
        .cyc_rewind (cyc_rewind),
        .rd_data    (fifo_rd),
        .count      (fifo_count),
        .empty      (fifo_empty),
        .ovf        (fifo_ovf)
    );

    xpt_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_data   (cmd_data),
        .byte_done  (byte_done),
        .fifo_empty (fifo_empty),
        .fifo_last  (fifo_last),
        .state_o    (state_q),
        .rep_o      (rep_q),
        .pop        (pop),
        .cyc_adv    (cyc_adv),
        .cyc_rewind (cyc_rewind),
        .fifo_clear (fifo_clear),
        .restart    (restart)
    );

    xpt_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (tx_clk_en),
        .sending   (sending),
        .restart   (restart),
        .byte_in   (byte_in),
        .tx_bit    (tx_bit),
        .byte_done (byte_done)
    );

endmodule

// File: rtl/xpt_tx_checker.sv
module xpt_tx_checker
    import xpt_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_wr,
    input logic [7:0]              cmd_data,
    input logic                    tx_clk_en,
    input logic                    tx_bit,
    input logic                    fifo_ovf,
    input tx_state_e               state,
    input logic                    rep_on,
    input logic [$clog2(DEPTH):0]  fill
);
    localparam int CW = $clog2(DEPTH) + 1;

    // R1: an idle shift slot always puts a one on the line
    a_r1_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && tx_clk_en) |=> tx_bit);

    // R2: the synchronization byte is all ones
    a_r2_sync_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC && tx_clk_en) |=> tx_bit);

    // R5: a command without the repeat bit ends cyclic sending at once
    a_r5_stop_cyclic: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && rep_on && !cmd_data[CMD_RESET_BIT] && !cmd_data[CMD_REPEAT_BIT])
        |=> (state == ST_IDLE && !rep_on));

    // R6: reset command empties everything within one clock
    a_r6_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_data[CMD_RESET_BIT])
        |=> (state == ST_IDLE && fill == '0 && !fifo_ovf && !rep_on));

    // R7: overflow flag is sticky until a reset command
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ovf && !(cmd_wr && cmd_data[CMD_RESET_BIT])) |=> fifo_ovf);

    // R7: the queue never holds more than its depth
    a_r7_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    // R8: the line holds between enable pulses
    a_r8_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_clk_en |=> $stable(tx_bit));

endmodule

bind xpt_cyclic_tx xpt_tx_checker #(
    .DEPTH (FIFO_DEPTH)
) u_xpt_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_data  (cmd_data),
    .tx_clk_en (tx_clk_en),
    .tx_bit    (tx_bit),
    .fifo_ovf  (fifo_ovf),
    .state     (state_q),
    .rep_on    (rep_q),
    .fill      (fifo_count)
);

// File: tb/test_xpt_cyclic_tx.sv
module test_xpt_cyclic_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_wr = 1'b0;
    logic [7:0] fifo_wdata = '0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_data = '0;
    logic       tx_clk_en = 1'b0;
    logic       tx_bit;
    logic       fifo_ovf;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    // stimulus byte [31:24]; expected line word [23:0], bit i sent i-th
    localparam int NVEC = 6;
    localparam logic [31:0] VECS [NVEC] = '{
        32'hA5_FFA5FF, 32'h00_FF00FF, 32'hFF_FFFFFF,
        32'h01_FF01FF, 32'h80_FF80FF, 32'h3C_FF3CFF
    };

    always #2 clk = ~clk;

    xpt_cyclic_tx i_xpt_cyclic_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata),
        .cmd_wr     (cmd_wr),
        .cmd_data   (cmd_data),
        .tx_clk_en  (tx_clk_en),
        .tx_bit     (tx_bit),
        .fifo_ovf   (fifo_ovf)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick_bit(output logic b);
        @(negedge clk);
        tx_clk_en = 1'b1;
        @(negedge clk);
        tx_clk_en = 1'b0;
        b = tx_bit;
    endtask

    task automatic get_byte(output logic [7:0] v);
        logic b;
        for (int i = 0; i < 8; i++) begin
            tick_bit(b);
            v[i] = b;
        end
    endtask

    task automatic expect_byte(input logic [7:0] e, input string req);
        logic [7:0] v;
        get_byte(v);
        check(v == e, req, 32'(v), 32'(e));
    endtask

    task automatic put_byte(input logic [7:0] v);
        @(negedge clk);
        fifo_wr = 1'b1;
        fifo_wdata = v;
        @(negedge clk);
        fifo_wr = 1'b0;
    endtask

    task automatic command(input logic [7:0] v);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_data = v;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            finish_run();
        end
    end

    initial begin
        logic [23:0] word;
        logic [7:0]  v;
        logic        b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(tx_bit == 1'b1, "R1 line after reset", 32'(tx_bit), 1);
        check(fifo_ovf == 1'b0, "R1 overflow after reset", 32'(fifo_ovf), 0);
        expect_byte(8'hFF, "R1 idle ones");

        // R2 table of one-shot single-byte transmissions
        for (int k = 0; k < NVEC; k++) begin
            put_byte(VECS[k][31:24]);
            command(8'h04);
            for (int i = 0; i < 24; i++) begin
                tick_bit(b);
                word[i] = b;
            end
            check(word == VECS[k][23:0], "R2 one-shot vector", 32'(word), 32'(VECS[k][23:0]));
        end

        // R4 cyclic three-byte pattern
        put_byte(8'h11);
        put_byte(8'h22);
        put_byte(8'h83);
        command(8'h24);
        expect_byte(8'hFF, "R4 sync before pattern");
        for (int r = 0; r < 3; r++) begin
            expect_byte(8'h11, "R4 pattern byte 0");
            expect_byte(8'h22, "R4 pattern byte 1");
            expect_byte(8'h83, "R4 pattern byte 2");
        end

        // R8 hold between pulses, mid byte 0x11 (bit 1 is 0)
        tick_bit(b); v[0] = b;
        tick_bit(b); v[1] = b;
        repeat (4) @(negedge clk);
        check(tx_bit == 1'b0, "R8 line held without enable", 32'(tx_bit), 0);
        for (int i = 2; i < 7; i++) begin
            tick_bit(b);
            v[i] = b;
        end
        // R5 keep-going command on the last bit of a byte
        @(negedge clk);
        tx_clk_en = 1'b1;
        cmd_wr = 1'b1;
        cmd_data = 8'h24;
        @(negedge clk);
        tx_clk_en = 1'b0;
        cmd_wr = 1'b0;
        v[7] = tx_bit;
        check(v == 8'h11, "R5 byte under repeat command", 32'(v), 32'h11);
        expect_byte(8'h22, "R5 pattern advances after command");
        expect_byte(8'h83, "R5 pattern continues");

        // R5 stop with repeat bit clear
        command(8'h04);
        expect_byte(8'hFF, "R5 ones after stop");
        expect_byte(8'hFF, "R5 ones after stop again");

        // R4 entries were not consumed: one-shot sends them
        command(8'h04);
        expect_byte(8'hFF, "R2 sync");
        expect_byte(8'h11, "R4 kept byte 0");
        expect_byte(8'h22, "R4 kept byte 1");
        expect_byte(8'h83, "R4 kept byte 2");
        expect_byte(8'hFF, "R2 idle after one-shot");

        // R3 start with empty queue
        command(8'h04);
        expect_byte(8'hFF, "R3 sync only");
        put_byte(8'h5A);
        expect_byte(8'hFF, "R3 late byte not sent");
        expect_byte(8'hFF, "R3 late byte still waiting");
        command(8'h04);
        expect_byte(8'hFF, "R3 sync on restart");
        expect_byte(8'h5A, "R3 waiting byte sent");
        expect_byte(8'hFF, "R3 idle after");

        // R6 reset command during cyclic sending
        put_byte(8'h0F);
        put_byte(8'hF0);
        command(8'h24);
        expect_byte(8'hFF, "R6 sync");
        expect_byte(8'h0F, "R6 first byte");
        command(8'h25);
        expect_byte(8'hFF, "R6 ones after reset command");
        command(8'h04);
        expect_byte(8'hFF, "R6 sync after reset");
        expect_byte(8'hFF, "R6 queue emptied");

        // R7 overflow on a full queue, 32-byte cyclic boundary
        for (int i = 0; i < 32; i++) begin
            put_byte(8'(i * 37 + 3));
        end
        @(negedge clk);
        check(fifo_ovf == 1'b0, "R7 no overflow at 32", 32'(fifo_ovf), 0);
        put_byte(8'hEE);
        @(negedge clk);
        check(fifo_ovf == 1'b1, "R7 overflow on 33rd write", 32'(fifo_ovf), 1);
        command(8'h24);
        expect_byte(8'hFF, "R4 sync for 32-byte pattern");
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 32; i++) begin
                expect_byte(8'(i * 37 + 3), "R4 32-byte pattern wrap");
            end
        end
        command(8'h00);
        expect_byte(8'hFF, "R7 rejected byte never sent");
        check(fifo_ovf == 1'b1, "R7 overflow sticky", 32'(fifo_ovf), 1);
        command(8'h01);
        @(negedge clk);
        check(fifo_ovf == 1'b0, "R6 reset clears overflow", 32'(fifo_ovf), 0);

        done = 1'b1;
        finish_run();
    end

endmodule